// File: doc/BRIEF.md
# SPI Status and Error Flag Unit

This block holds the status flags, the error flags and the interrupt line of a byte-wide SPI peripheral. A CPU reaches it through three registers: control, status and data. The serial shift engine drives it through a small set of strobes. The engine reports a transfer in progress, a finished byte together with its received value, and the level of the slave-select input. The unit keeps four flags: byte done, write collision, overrun and mode fault. It applies the effect of a mode fault on the enable and master control bits. It accepts or rejects CPU writes to the transmit byte, and it keeps the received byte that the CPU reads back.

Most flags clear only through an ordered pair of register accesses. The first access is a status read taken while the flag is set, which arms that flag. The second access, made later, clears only the flags that were armed. Other register accesses may fall between the two steps. A mode fault drops the peripheral out of master mode and locks the enable and master bits until its own clearing sequence completes. During an overrun the unit keeps the first unread byte and throws away every byte that arrives after it.

Register select codes are 0 for control, 1 for status and 2 for data. Code 3 reads as zero. Control bits: bit 0 enable, bit 1 master, bit 2 interrupt enable. Status bits: bit 7 byte done, bit 6 write collision, bit 5 overrun, bit 4 mode fault. All other bits read as zero. An access takes effect at the rising clock edge where its strobe is high, and read data is valid during that cycle.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset, every flag is 0, the control register reads 0x00, the status register reads 0x00, `irq` is 0 and `tx_load` is 0.
- R2: When the master bit is 1 and `ss_in_n` is low at a clock edge, from the next cycle the mode fault bit (status bit 4) reads 1, the enable and master bits read 0, and `irq` is 1 if interrupt enable is 1.
- R3: While the master bit is 0, a low `ss_in_n` never sets the mode fault bit and leaves the control register unchanged.
- R4: While mode fault is set and not armed, a control write cannot set the enable or master bits. It can clear them, and it writes the interrupt enable bit normally. The write does not clear mode fault.
- R5: A status read while mode fault is 1, followed by a control write, clears mode fault. That control write is applied in full, including enable and master.
- R6: A byte completion (`byte_done`) while byte done is already set, and not being cleared in that cycle, sets overrun (status bit 5) from the next cycle and raises `irq` if interrupt enable is 1.
- R7: During an overrun, the data register returns the byte that set byte done. Every byte completed after it is discarded until byte done clears.
- R8: Any status read that sees overrun set returns it as 1 and clears it. Byte done is not changed by that read.
- R9: A data-register write while `xfer_busy` is 1 sets write collision (status bit 6), does not pulse `tx_load` and leaves `tx_data` unchanged. A data write while `xfer_busy` is 0 gives a one-cycle `tx_load` pulse in the next cycle, with `tx_data` holding the written byte.
- R10: Write collision never raises `irq`. It clears only through a status read that sees it set followed by a data read. A data write does not clear it.
- R11: A `byte_done` strobe sets byte done (status bit 7) and loads `rx_byte` into the data register. Byte done clears only through a status read that sees it set followed by a data read. A data read without that prior status read leaves it set.
- R12: `irq` is a level equal to interrupt enable AND (byte done OR overrun OR mode fault). It drops once those flags clear.
- R13: If an armed data read and a `byte_done` fall in the same cycle, the read returns the old byte. Byte done stays 1, overrun stays 0, and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| rd_en | input | 1 | CPU read strobe for the selected register |
| wr_en | input | 1 | CPU write strobe for the selected register |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | CPU read data for the selected register |
| xfer_busy | input | 1 | Shift engine is moving a byte |
| byte_done | input | 1 | One-cycle strobe: a byte transfer finished |
| rx_byte | input | 8 | Byte received by the shift engine, valid with byte_done |
| ss_in_n | input | 1 | Slave-select input level, active low |
| ctl_enable | output | 1 | Peripheral enable bit |
| ctl_master | output | 1 | Master mode bit |
| ctl_irq_en | output | 1 | Interrupt enable bit |
| tx_load | output | 1 | One-cycle pulse: an accepted byte is ready to shift out |
| tx_data | output | 8 | Last accepted transmit byte |
| irq | output | 1 | Level interrupt request |

## Verification
The case that needs the most care is a data read that completes the byte-done clearing sequence in the same cycle that the shift engine reports another finished byte. The bench arms the flag with a status read. It then raises the data read strobe and `byte_done` on the same edge. The read must return the old byte, byte done must remain set, and no overrun may appear. A later data read must then return the new byte. The bench also checks the case where a byte arrives without any clearing, and there overrun must be set and the stored byte must not change.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int CB_EN = 0;
  localparam int CB_MS = 1;
  localparam int CB_IE = 2;

  // status register bit positions
  localparam int SB_DONE = 7;
  localparam int SB_WCOL = 6;
  localparam int SB_OVR  = 5;
  localparam int SB_MODF = 4;

endpackage

// File: rtl/spi_flag_rst_sync.sv
module spi_flag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fault_set_i,
  input  logic              lock_i,
  output logic              en_o,
  output logic              ms_o,
  output logic              ie_o
);

  logic en_q, ms_q, ie_q;
  logic en_d, ms_d, ie_d;

  always_comb begin
    en_d = en_q;
    ms_d = ms_q;
    ie_d = ie_q;
    if (wr_ctl_i) begin
      ie_d = wr_data_i[CB_IE];
      if (lock_i) begin
        // locked: bits may only fall
        en_d = en_q & wr_data_i[CB_EN];
        ms_d = ms_q & wr_data_i[CB_MS];
      end else begin
        en_d = wr_data_i[CB_EN];
        ms_d = wr_data_i[CB_MS];
      end
    end
    if (fault_set_i) begin
      en_d = 1'b0;
      ms_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ms_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      en_q <= en_d;
      ms_q <= ms_d;
      ie_q <= ie_d;
    end
  end

  assign en_o = en_q;
  assign ms_o = ms_q;
  assign ie_o = ie_q;

  // R2: a fault forces enable and master low
  a_r2_fault_drops_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set_i |=> (!en_q && !ms_q));

  // R4: locked writes never raise master or enable
  a_r4_lock_master: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !ms_q) |=> !ms_q);
  a_r4_lock_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !en_q) |=> !en_q);

endmodule

// File: rtl/spi_flag_status.sv
module spi_flag_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stat_i,
  input  logic rd_data_i,
  input  logic wr_ctl_i,
  input  logic wr_dreg_i,
  input  logic busy_i,
  input  logic byte_done_i,
  input  logic ss_n_i,
  input  logic master_i,
  output logic done_o,
  output logic wcol_o,
  output logic ovr_o,
  output logic modf_o,
  output logic fault_set_o,
  output logic lock_o,
  output logic rx_accept_o,
  output logic tx_accept_o
);

  logic done_q, wcol_q, ovr_q, modf_q;
  logic done_arm_q, wcol_arm_q, modf_arm_q;
  logic done_d, wcol_d, ovr_d, modf_d;
  logic done_arm_d, wcol_arm_d, modf_arm_d;

  logic modf_set, modf_clr;
  logic done_clr, wcol_clr, ovr_clr;
  logic ovr_set, wcol_set;

  always_comb begin
    modf_set = master_i & ~ss_n_i;
    modf_clr = modf_arm_q & wr_ctl_i;
    done_clr = done_arm_q & rd_data_i;
    wcol_clr = wcol_arm_q & rd_data_i;
    ovr_clr  = ovr_q & rd_stat_i;
    ovr_set  = byte_done_i & done_q & ~done_clr;
    wcol_set = wr_dreg_i & busy_i;

    // set has priority over clear in every flag
    done_d = byte_done_i | (done_q & ~done_clr);
    wcol_d = wcol_set    | (wcol_q & ~wcol_clr);
    ovr_d  = ovr_set     | (ovr_q  & ~ovr_clr);
    modf_d = modf_set    | (modf_q & ~modf_clr);

    // arming needs a status read that sees the flag set
    done_arm_d = done_q & ~done_clr & (done_arm_q | rd_stat_i);
    wcol_arm_d = wcol_q & ~wcol_clr & (wcol_arm_q | rd_stat_i);
    modf_arm_d = modf_q & ~modf_clr & (modf_arm_q | rd_stat_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      wcol_q     <= 1'b0;
      ovr_q      <= 1'b0;
      modf_q     <= 1'b0;
      done_arm_q <= 1'b0;
      wcol_arm_q <= 1'b0;
      modf_arm_q <= 1'b0;
    end else begin
      done_q     <= done_d;
      wcol_q     <= wcol_d;
      ovr_q      <= ovr_d;
      modf_q     <= modf_d;
      done_arm_q <= done_arm_d;
      wcol_arm_q <= wcol_arm_d;
      modf_arm_q <= modf_arm_d;
    end
  end

  assign done_o      = done_q;
  assign wcol_o      = wcol_q;
  assign ovr_o       = ovr_q;
  assign modf_o      = modf_q;
  assign fault_set_o = modf_set;
  assign lock_o      = modf_q & ~modf_clr;
  assign rx_accept_o = byte_done_i & ~ovr_set;
  assign tx_accept_o = wr_dreg_i & ~busy_i;

  // R3: no fault can appear while in slave mode
  a_r3_no_fault_in_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !modf_q) |=> !modf_q);

  // R6: a byte on top of an uncleared one flags overrun
  a_r6_overrun_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && done_q && !done_clr) |=> ovr_q);

  // R9: write during a transfer flags collision
  a_r9_collision_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dreg_i && busy_i) |=> wcol_q);

  // R10: collision survives anything but a data read
  a_r10_wcol_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_q && !rd_data_i) |=> wcol_q);

  // R11: byte done survives anything but a data read
  a_r11_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !rd_data_i) |=> done_q);

endmodule

// File: rtl/spi_flag_buf.sv
module spi_flag_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_accept_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              tx_accept_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_q_o,
  output logic [DATA_W-1:0] tx_q_o,
  output logic              tx_load_o
);

  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              load_q, load_d;

  always_comb begin
    rx_d   = rx_accept_i ? rx_byte_i : rx_q;
    tx_d   = tx_accept_i ? tx_byte_i : tx_q;
    load_d = tx_accept_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      tx_q   <= '0;
      load_q <= 1'b0;
    end else begin
      if (rx_accept_i) rx_q <= rx_d;
      if (tx_accept_i) tx_q <= tx_d;
      load_q <= load_d;
    end
  end

  assign rx_q_o    = rx_q;
  assign tx_q_o    = tx_q;
  assign tx_load_o = load_q;

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              xfer_busy,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              ss_in_n,
  output logic              ctl_enable,
  output logic              ctl_master,
  output logic              ctl_irq_en,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);

  logic     rst_sync_n;
  reg_sel_e sel;
  logic     rd_stat, rd_dreg, wr_ctl, wr_dreg;
  logic     done, wcol, ovr, modf;
  logic     fault_set, lock, rx_accept, tx_accept;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] ctrl_word, stat_word;

  spi_flag_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sel     = reg_sel_e'(reg_sel);
    rd_stat = rd_en & (sel == SEL_STAT);
    rd_dreg = rd_en & (sel == SEL_DATA);
    wr_ctl  = wr_en & (sel == SEL_CTRL);
    wr_dreg = wr_en & (sel == SEL_DATA);
  end

  spi_flag_status u_stat (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rd_stat_i   (rd_stat),
    .rd_data_i   (rd_dreg),
    .wr_ctl_i    (wr_ctl),
    .wr_dreg_i   (wr_dreg),
    .busy_i      (xfer_busy),
    .byte_done_i (byte_done),
    .ss_n_i      (ss_in_n),
    .master_i    (ctl_master),
    .done_o      (done),
    .wcol_o      (wcol),
    .ovr_o       (ovr),
    .modf_o      (modf),
    .fault_set_o (fault_set),
    .lock_o      (lock),
    .rx_accept_o (rx_accept),
    .tx_accept_o (tx_accept)
  );

  spi_flag_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_ctl_i    (wr_ctl),
    .wr_data_i   (wr_data),
    .fault_set_i (fault_set),
    .lock_i      (lock),
    .en_o        (ctl_enable),
    .ms_o        (ctl_master),
    .ie_o        (ctl_irq_en)
  );

  spi_flag_buf #(.DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rx_accept_i (rx_accept),
    .rx_byte_i   (rx_byte),
    .tx_accept_i (tx_accept),
    .tx_byte_i   (wr_data),
    .rx_q_o      (rx_q),
    .tx_q_o      (tx_data),
    .tx_load_o   (tx_load)
  );

  always_comb begin
    ctrl_word        = '0;
    ctrl_word[CB_EN] = ctl_enable;
    ctrl_word[CB_MS] = ctl_master;
    ctrl_word[CB_IE] = ctl_irq_en;
    stat_word          = '0;
    stat_word[SB_DONE] = done;
    stat_word[SB_WCOL] = wcol;
    stat_word[SB_OVR]  = ovr;
    stat_word[SB_MODF] = modf;
    unique case (sel)
      SEL_CTRL: rd_data = ctrl_word;
      SEL_STAT: rd_data = stat_word;
      SEL_DATA: rd_data = rx_q;
      default:  rd_data = '0;
    endcase
    irq = ctl_irq_en & (done | ovr | modf);
  end

  // R9: a rejected write never produces a load pulse
  a_r9_no_load_on_collision: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_dreg && xfer_busy) |=> !tx_load);

  // R7: stored byte is frozen while an unread byte is pending
  a_r7_buffer_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !rd_dreg) |=> $stable(rx_q));

endmodule

// File: tb/tb_spi_flag_unit.sv
`timescale 1ns/1ps
module tb_spi_flag_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       rd_en, wr_en;
  logic [7:0] wr_data, rd_data;
  logic       xfer_busy, byte_done, ss_in_n;
  logic [7:0] rx_byte;
  logic       ctl_enable, ctl_master, ctl_irq_en, tx_load, irq;
  logic [7:0] tx_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .xfer_busy(xfer_busy),
    .byte_done(byte_done), .rx_byte(rx_byte), .ss_in_n(ss_in_n),
    .ctl_enable(ctl_enable), .ctl_master(ctl_master), .ctl_irq_en(ctl_irq_en),
    .tx_load(tx_load), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 tx_load", {7'd0, tx_load}, 8'h00);
    rd(2'd0, d); check("R1 control", d, 8'h00);
    rd(2'd1, d); check("R1 status", d, 8'h00);
  endtask

  task automatic t_mode_fault();
    logic [7:0] d;
    wr(2'd0, 8'h07);
    rd(2'd0, d); check("R2 control before fault", d, 8'h07);
    @(negedge clk); ss_in_n = 1'b0;
    @(negedge clk); ss_in_n = 1'b1;
    rd(2'd0, d); check("R2 control after fault", d, 8'h04);
    check("R2 irq on fault", {7'd0, irq}, 8'h01);
    check("R12 irq level", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h07);                    // locked write
    rd(2'd0, d); check("R4 locked write", d, 8'h04);
    rd(2'd1, d); check("R4 fault kept", d, 8'h10);  // arms
    wr(2'd0, 8'h03);                    // completes sequence
    rd(2'd0, d); check("R5 full write", d, 8'h03);
    rd(2'd1, d); check("R5 fault cleared", d, 8'h00);
    check("R12 irq dropped", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h01);                    // slave
    @(negedge clk); ss_in_n = 1'b0;
    @(negedge clk); @(negedge clk); ss_in_n = 1'b1;
    rd(2'd1, d); check("R3 no fault in slave", d, 8'h00);
    rd(2'd0, d); check("R3 control kept", d, 8'h01);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_done();
    logic [7:0] d;
    send_byte(8'hB1);
    rd(2'd2, d); check("R11 data", d, 8'hB1);
    rd(2'd1, d); check("R11 unarmed read keeps done", d, 8'h80);
    rd(2'd2, d);
    rd(2'd1, d); check("R11 cleared", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    wr(2'd0, 8'h04);
    send_byte(8'hA1);
    check("R12 irq on done", {7'd0, irq}, 8'h01);
    rd(2'd1, d); check("R11 done set", d, 8'h80);
    send_byte(8'hA2);
    check("R6 irq", {7'd0, irq}, 8'h01);
    send_byte(8'hA3);
    rd(2'd1, d); check("R6 overrun set", d, 8'hA0);
    rd(2'd1, d); check("R8 overrun cleared", d, 8'h80);
    rd(2'd2, d); check("R7 first byte kept", d, 8'hA1);
    rd(2'd1, d); check("R7 flags clear", d, 8'h00);
    check("R12 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    @(negedge clk); xfer_busy = 1'b1;
    @(negedge clk); reg_sel = 2'd2; wr_data = 8'h5A; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R9 no load", {7'd0, tx_load}, 8'h00);
    check("R9 tx_data kept", tx_data, 8'h00);
    check("R10 no irq", {7'd0, irq}, 8'h00);
    xfer_busy = 1'b0;
    rd(2'd1, d); check("R9 wcol set", d, 8'h40);
    @(negedge clk); reg_sel = 2'd2; wr_data = 8'h3C; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R9 load pulse", {7'd0, tx_load}, 8'h01);
    check("R9 tx_data", tx_data, 8'h3C);
    @(negedge clk);
    check("R9 pulse one cycle", {7'd0, tx_load}, 8'h00);
    rd(2'd1, d); check("R10 write keeps wcol", d, 8'h40);
    rd(2'd2, d);
    rd(2'd1, d); check("R10 wcol cleared", d, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    send_byte(8'hC1);
    rd(2'd1, d);                        // arms
    @(negedge clk);
    reg_sel = 2'd2; rd_en = 1'b1; rx_byte = 8'hC2; byte_done = 1'b1;
    #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0; byte_done = 1'b0;
    check("R13 old byte read", d, 8'hC1);
    rd(2'd1, d); check("R13 done kept no overrun", d, 8'h80);
    rd(2'd2, d); check("R13 new byte stored", d, 8'hC2);
    rd(2'd1, d); check("R13 cleared", d, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 2'd0; rd_en = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    xfer_busy = 1'b0; byte_done = 1'b0; rx_byte = 8'h00; ss_in_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mode_fault();
    t_done();
    t_overrun();
    t_collision();
    t_same_cycle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule